// File: doc/BRIEF.md
# Multi-Page-Size Associative Translation Buffer

This block translates a 64-bit virtual address for data accesses by comparing it against every entry of a fully associative buffer at once. Entries of four page sizes (8 KB, 64 KB, 512 KB, 4 MB) share the array. The compare masks off more low tag bits for larger pages. An entry flagged global matches under any context. A request names a context source: primary, secondary or nucleus. From that source the block forms a 13-bit lookup context. It then returns a physical address together with one outcome: a clean hit with read/write rights, a data access fault, a protection trap or a miss.

On a fault, a protection trap or a miss the block maintains three observable registers: a fault status word, a fault address and a tag-access word. A single write port loads one entry per cycle; software refill of the buffer happens outside this block. A translation-disable input lets addresses pass through unmapped.

Top module: `tlb_assoc`

## Requirements
- R1: Entry page-size code 0/1/2/3 means 8 KB/64 KB/512 KB/4 MB; virtual address bits below bit 13/16/19/22 respectively take no part in the compare, and an address one page beyond the entry misses.
- R2: An entry matches only when its valid bit is set and either its global bit is set or its stored context equals the lookup context; an entry written through the write port takes part in lookups from the next cycle.
- R3: On a hit, `rspPa` holds the entry's physical page bits above the page-size boundary and the virtual address bits below it, limited to 41 bits, with bits 12:0 forced to zero.
- R4: `reqCtxSel` 0 selects `primaryCtx`, 1 selects `secondaryCtx`, 2 or 3 selects context 0 (nucleus); `faultStatus[4:3]` records 0, 1 or 2 accordingly.
- R5: `reqKind` is 0 load, 1 store, 2 non-faulting load. A user access to a privileged page sets `faultStatus[7]`. A non-faulting load to a side-effect page sets `faultStatus[8]`. A load or store to a no-fault-only page sets `faultStatus[9]`. Several of these bits may be set at once, and any of them raises `trapFault`.
- R6: A store that hits a page without write permission and has no R5 fault raises `trapProt` instead; the status word is still written, with bits 9:7 clear.
- R7: A hit with neither fault nor protection trap gives `rspRead`=1 and `rspWriteOk` equal to the page's write permission, and sets that entry's used flag (readable on `rdUsed` through `rdIdx`); newly written entries have the flag clear.
- R8: On `trapFault` or `trapProt` the status word gets bit 0 (valid) set, bit 1 (overwrite) set if bit 0 was already set and `statusClr` was low, bit 2 = `privMode`, bit 5 = store, bit 6 = non-faulting load, and `faultAddr` takes the request address; `statusClr` alone zeroes the status word.
- R9: On a fault, protection trap or miss, `tagAccess` becomes virtual address bits 63:13 above the 13-bit lookup context.
- R10: A lookup that matches no entry raises `trapMiss` alone and leaves `faultStatus` and `faultAddr` unchanged.
- R11: With `mmuEnable` low, `rspPa` is the request address bits 40:0, `rspRead` and `rspWriteOk` are 1, no trap is raised, and no register or used flag changes.
- R12: When several entries match, the lowest-numbered one is used; every response appears exactly one clock after the request and `rspValid` is high for that one cycle.
- R13: After reset all entries are invalid and every response, trap and status output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write one entry this cycle |
| wrIdx | input | 6 | Entry index to write |
| wrVpn | input | 51 | Virtual page bits 63:13 of the entry tag |
| wrCtx | input | 13 | Entry context |
| wrValid | input | 1 | Entry valid |
| wrGlobal | input | 1 | Entry matches any context |
| wrSize | input | 2 | Page-size code |
| wrPriv | input | 1 | Privileged-only page |
| wrWritable | input | 1 | Write permission |
| wrNfo | input | 1 | Page accepts only non-faulting loads |
| wrSideEff | input | 1 | Page has side effects |
| wrPpn | input | 28 | Physical page bits 40:13 |
| reqValid | input | 1 | Lookup request |
| reqVa | input | 64 | Virtual address |
| reqKind | input | 2 | 0 load, 1 store, 2 non-faulting load |
| reqUser | input | 1 | Access made in user mode |
| reqCtxSel | input | 2 | Context source: 0 primary, 1 secondary, 2/3 nucleus |
| privMode | input | 1 | Processor privileged-mode flag copied into status |
| mmuEnable | input | 1 | Translation enabled |
| primaryCtx | input | 13 | Primary context value |
| secondaryCtx | input | 13 | Secondary context value |
| statusClr | input | 1 | Clear the status word |
| rdIdx | input | 6 | Entry whose used flag is shown |
| rdUsed | output | 1 | Used flag of entry `rdIdx` |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | An entry matched |
| rspRead | output | 1 | Read granted |
| rspWriteOk | output | 1 | Write granted |
| rspPa | output | 41 | Physical address |
| trapFault | output | 1 | Data access fault |
| trapProt | output | 1 | Write protection trap |
| trapMiss | output | 1 | No matching entry |
| faultStatus | output | 10 | Fault status word |
| faultAddr | output | 64 | Captured fault address |
| tagAccess | output | 64 | Virtual page and context of last fault or miss |

## Verification
Every lookup result appears on the clock edge that follows the request. The status word, fault address, tag-access word and used flag all change on that same edge. The bench applies a request after a falling edge and compares all outputs after the next falling edge, so exactly one rising edge lies between stimulus and sample. The used flag is read back through the combinational `rdIdx` port after that edge. The `rspValid` drop is checked one further cycle later.

// File: rtl/tlb_assoc_pkg.sv
package tlb_assoc_pkg;
  localparam int VA_W        = 64;
  localparam int PA_W        = 41;
  localparam int CTX_W       = 13;
  localparam int PAGE_SHIFT  = 13;
  localparam int TLB_ENTRIES = 64;
  localparam int SIZE_STEP   = 3;
  localparam int IDX_W       = $clog2(TLB_ENTRIES);
  localparam int VPN_W       = VA_W - PAGE_SHIFT;
  localparam int PPN_W       = PA_W - PAGE_SHIFT;
  localparam int TAG_W       = VPN_W + CTX_W;

  localparam logic [1:0] ACC_STORE  = 2'd1;
  localparam logic [1:0] ACC_NFLOAD = 2'd2;
  localparam logic [1:0] CTXK_PRI   = 2'd0;
  localparam logic [1:0] CTXK_SEC   = 2'd1;
  localparam logic [1:0] CTXK_NUC   = 2'd2;

  typedef struct packed {
    logic             valid;
    logic             global;
    logic [1:0]       size;
    logic             priv;
    logic             writable;
    logic             nfo;
    logic             sideEff;
    logic             used;
    logic [PPN_W-1:0] ppn;
  } tte_t;

  typedef struct packed {
    logic       ftNfo;
    logic       ftSideEff;
    logic       ftPriv;
    logic       nfAccess;
    logic       writeAccess;
    logic [1:0] ctxKind;
    logic       privMode;
    logic       overwrite;
    logic       valid;
  } fsr_t;

  localparam int FSR_W = $bits(fsr_t);

  typedef struct packed {
    logic             setUsed;
    logic [IDX_W-1:0] usedIdx;
  } ctlStrobe_t;

  function automatic logic [VPN_W-1:0] vpnMask(input logic [1:0] size);
    vpnMask = ~((VPN_W'(1) << (SIZE_STEP * int'(size))) - VPN_W'(1));
  endfunction
endpackage

// File: rtl/tlb_assoc_dp.sv
module tlb_assoc_dp
  import tlb_assoc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [CTX_W-1:0] wrCtx,
  input  tte_t             wrTte,
  input  logic [VPN_W-1:0] lookVpn,
  input  logic [CTX_W-1:0] lookCtx,
  input  ctlStrobe_t       strobe,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdUsed,
  output logic             hitAny,
  output logic [IDX_W-1:0] hitIdx,
  output logic             hitPriv,
  output logic             hitWritable,
  output logic             hitNfo,
  output logic             hitSideEff,
  output logic [PPN_W-1:0] hitPpn
);
  tte_t             tteMem [TLB_ENTRIES];
  logic [VPN_W-1:0] tagVpn [TLB_ENTRIES];
  logic [CTX_W-1:0] tagCtx [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0] selMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        tteMem[i] <= '0;
        tagVpn[i] <= '0;
        tagCtx[i] <= '0;
      end
    end else begin
      if (strobe.setUsed) tteMem[strobe.usedIdx].used <= 1'b1;
      if (wrEn) begin
        tteMem[wrIdx] <= wrTte;
        tagVpn[wrIdx] <= wrVpn;
        tagCtx[wrIdx] <= wrCtx;
      end
    end
  end

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : g_match
    assign matchVec[g] = tteMem[g].valid
                      && (tteMem[g].global || (tagCtx[g] == lookCtx))
                      && (((tagVpn[g] ^ lookVpn) & vpnMask(tteMem[g].size)) == '0);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hitAny      = |matchVec;
  assign hitPriv     = tteMem[hitIdx].priv;
  assign hitWritable = tteMem[hitIdx].writable;
  assign hitNfo      = tteMem[hitIdx].nfo;
  assign hitSideEff  = tteMem[hitIdx].sideEff;
  assign selMask     = vpnMask(tteMem[hitIdx].size);
  assign hitPpn      = (tteMem[hitIdx].ppn & selMask[PPN_W-1:0])
                     | (lookVpn[PPN_W-1:0] & ~selMask[PPN_W-1:0]);
  assign rdUsed      = tteMem[rdIdx].used;
endmodule

// File: rtl/tlb_assoc_ctl.sv
module tlb_assoc_ctl
  import tlb_assoc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqKind,
  input  logic             reqUser,
  input  logic [1:0]       reqCtxSel,
  input  logic             privMode,
  input  logic             mmuEnable,
  input  logic [CTX_W-1:0] primaryCtx,
  input  logic [CTX_W-1:0] secondaryCtx,
  input  logic             statusClr,
  input  logic             hitAny,
  input  logic [IDX_W-1:0] hitIdx,
  input  logic             hitPriv,
  input  logic             hitWritable,
  input  logic             hitNfo,
  input  logic             hitSideEff,
  input  logic [PPN_W-1:0] hitPpn,
  output logic [CTX_W-1:0] lookCtx,
  output ctlStrobe_t       strobe,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspRead,
  output logic             rspWriteOk,
  output logic [PA_W-1:0]  rspPa,
  output logic             trapFault,
  output logic             trapProt,
  output logic             trapMiss,
  output fsr_t             faultStatus,
  output logic [VA_W-1:0]  faultAddr,
  output logic [TAG_W-1:0] tagAccess
);
  logic [1:0] ctxKind;
  logic isStore, isNf, active;
  logic ftPriv, ftSe, ftNfo, anyFault, protErr, cleanHit, doFault, doMiss;
  fsr_t newFsr;

  always_comb begin
    case (reqCtxSel)
      2'd0:    begin ctxKind = CTXK_PRI; lookCtx = primaryCtx;   end
      2'd1:    begin ctxKind = CTXK_SEC; lookCtx = secondaryCtx; end
      default: begin ctxKind = CTXK_NUC; lookCtx = '0;           end
    endcase
  end

  assign isStore  = (reqKind == ACC_STORE);
  assign isNf     = (reqKind == ACC_NFLOAD);
  assign active   = reqValid && mmuEnable;
  assign ftPriv   = hitPriv && reqUser;
  assign ftSe     = isNf && hitSideEff;
  assign ftNfo    = !isNf && hitNfo;
  assign anyFault = hitAny && (ftPriv || ftSe || ftNfo);
  assign protErr  = hitAny && !anyFault && isStore && !hitWritable;
  assign cleanHit = hitAny && !anyFault && !protErr;
  assign doFault  = active && (anyFault || protErr);
  assign doMiss   = active && !hitAny;

  always_comb begin
    newFsr             = '0;
    newFsr.valid       = 1'b1;
    newFsr.overwrite   = faultStatus.valid && !statusClr;
    newFsr.privMode    = privMode;
    newFsr.ctxKind     = ctxKind;
    newFsr.writeAccess = isStore;
    newFsr.nfAccess    = isNf;
    newFsr.ftPriv      = ftPriv;
    newFsr.ftSideEff   = ftSe;
    newFsr.ftNfo       = ftNfo;
  end

  assign strobe.setUsed = active && cleanHit;
  assign strobe.usedIdx = hitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspRead    <= 1'b0;
      rspWriteOk <= 1'b0;
      rspPa      <= '0;
      trapFault  <= 1'b0;
      trapProt   <= 1'b0;
      trapMiss   <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      rspHit     <= active && hitAny;
      rspRead    <= reqValid && (!mmuEnable || cleanHit);
      rspWriteOk <= reqValid && (!mmuEnable || (cleanHit && hitWritable));
      trapFault  <= active && anyFault;
      trapProt   <= active && protErr;
      trapMiss   <= doMiss;
      if (!reqValid)      rspPa <= '0;
      else if (!mmuEnable) rspPa <= reqVa[PA_W-1:0];
      else if (hitAny)    rspPa <= {hitPpn, {PAGE_SHIFT{1'b0}}};
      else                rspPa <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultStatus <= '0;
      faultAddr   <= '0;
      tagAccess   <= '0;
    end else begin
      if (doFault) begin
        faultStatus <= newFsr;
        faultAddr   <= reqVa;
      end else if (statusClr) begin
        faultStatus <= '0;
      end
      if (doFault || doMiss) tagAccess <= {reqVa[VA_W-1:PAGE_SHIFT], lookCtx};
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_assoc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [CTX_W-1:0] wrCtx,
  input  logic             wrValid,
  input  logic             wrGlobal,
  input  logic [1:0]       wrSize,
  input  logic             wrPriv,
  input  logic             wrWritable,
  input  logic             wrNfo,
  input  logic             wrSideEff,
  input  logic [PPN_W-1:0] wrPpn,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqKind,
  input  logic             reqUser,
  input  logic [1:0]       reqCtxSel,
  input  logic             privMode,
  input  logic             mmuEnable,
  input  logic [CTX_W-1:0] primaryCtx,
  input  logic [CTX_W-1:0] secondaryCtx,
  input  logic             statusClr,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdUsed,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspRead,
  output logic             rspWriteOk,
  output logic [PA_W-1:0]  rspPa,
  output logic             trapFault,
  output logic             trapProt,
  output logic             trapMiss,
  output logic [FSR_W-1:0] faultStatus,
  output logic [VA_W-1:0]  faultAddr,
  output logic [TAG_W-1:0] tagAccess
);
  tte_t             wrTte;
  ctlStrobe_t       strobe;
  logic [CTX_W-1:0] lookCtx;
  logic             hitAny, hitPriv, hitWritable, hitNfo, hitSideEff;
  logic [IDX_W-1:0] hitIdx;
  logic [PPN_W-1:0] hitPpn;
  fsr_t             fsrQ;

  always_comb begin
    wrTte          = '0;
    wrTte.valid    = wrValid;
    wrTte.global   = wrGlobal;
    wrTte.size     = wrSize;
    wrTte.priv     = wrPriv;
    wrTte.writable = wrWritable;
    wrTte.nfo      = wrNfo;
    wrTte.sideEff  = wrSideEff;
    wrTte.ppn      = wrPpn;
  end

  tlb_assoc_dp u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrCtx(wrCtx),
    .wrTte(wrTte), .lookVpn(reqVa[VA_W-1:PAGE_SHIFT]), .lookCtx(lookCtx), .strobe(strobe),
    .rdIdx(rdIdx), .rdUsed(rdUsed), .hitAny(hitAny), .hitIdx(hitIdx), .hitPriv(hitPriv),
    .hitWritable(hitWritable), .hitNfo(hitNfo), .hitSideEff(hitSideEff), .hitPpn(hitPpn)
  );

  tlb_assoc_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa), .reqKind(reqKind),
    .reqUser(reqUser), .reqCtxSel(reqCtxSel), .privMode(privMode), .mmuEnable(mmuEnable),
    .primaryCtx(primaryCtx), .secondaryCtx(secondaryCtx), .statusClr(statusClr),
    .hitAny(hitAny), .hitIdx(hitIdx), .hitPriv(hitPriv), .hitWritable(hitWritable),
    .hitNfo(hitNfo), .hitSideEff(hitSideEff), .hitPpn(hitPpn), .lookCtx(lookCtx),
    .strobe(strobe), .rspValid(rspValid), .rspHit(rspHit), .rspRead(rspRead),
    .rspWriteOk(rspWriteOk), .rspPa(rspPa), .trapFault(trapFault), .trapProt(trapProt),
    .trapMiss(trapMiss), .faultStatus(fsrQ), .faultAddr(faultAddr), .tagAccess(tagAccess)
  );

  assign faultStatus = fsrQ;
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk
  import tlb_assoc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             mmuEnable,
  input logic             statusClr,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspRead,
  input logic             trapFault,
  input logic             trapProt,
  input logic             trapMiss,
  input logic [FSR_W-1:0] faultStatus,
  input logic [VA_W-1:0]  faultAddr
);
  p_one_trap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapFault, trapProt, trapMiss}));

  p_rsp_next_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_rsp_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_fault_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (trapFault || trapProt) |-> faultStatus[0]);

  p_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((trapFault || trapProt) && $past(faultStatus[0]) && !$past(statusClr)) |-> faultStatus[1]);

  p_miss_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (trapMiss && !$past(statusClr)) |-> ($stable(faultStatus) && $stable(faultAddr)));

  p_bypass_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mmuEnable) |=> (!trapFault && !trapProt && !trapMiss && rspRead));

  p_clean_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && !trapFault && !trapProt) |-> rspRead);

  p_trap_on_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (trapFault || trapProt) |-> rspHit);
endmodule

bind tlb_assoc tlb_assoc_chk i_chk (.*);

// File: tb/test_tlb_assoc.sv
`timescale 1ns/1ps
module test_tlb_assoc;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, wrValid = 0, wrGlobal = 0, wrPriv = 0, wrWritable = 0, wrNfo = 0, wrSideEff = 0;
  logic [5:0] wrIdx = 0, rdIdx = 0;
  logic [50:0] wrVpn = 0;
  logic [12:0] wrCtx = 0, primaryCtx = 0, secondaryCtx = 0;
  logic [1:0] wrSize = 0, reqKind = 0, reqCtxSel = 0;
  logic [27:0] wrPpn = 0;
  logic reqValid = 0, reqUser = 0, privMode = 0, mmuEnable = 1, statusClr = 0;
  logic [63:0] reqVa = 0;
  logic rdUsed, rspValid, rspHit, rspRead, rspWriteOk, trapFault, trapProt, trapMiss;
  logic [40:0] rspPa;
  logic [9:0] faultStatus;
  logic [63:0] faultAddr, tagAccess;

  tlb_assoc i_tlb_assoc (.*);

  always #2.5 clk = ~clk;

  logic mValid[64], mGlob[64], mPriv[64], mWr[64], mNfo[64], mSe[64], mUsed[64];
  logic [1:0] mSize[64];
  logic [50:0] mVpn[64];
  logic [12:0] mCtx[64];
  logic [27:0] mPpn[64];
  logic [9:0] sFsr = 0;
  logic [63:0] sFar = 0, sTag = 0;
  int nChk = 0, nBad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [50:0] bMask(input logic [1:0] sz);
    return ~((51'd1 << (int'(sz) * 3)) - 51'd1);
  endfunction

  task automatic putEntry(input int idx, input logic [50:0] vpn, input logic [12:0] ctx,
                          input logic v, input logic g, input logic [1:0] sz, input logic p,
                          input logic w, input logic n, input logic s, input logic [27:0] ppn);
    @(negedge clk);
    wrEn = 1; wrIdx = 6'(idx); wrVpn = vpn; wrCtx = ctx; wrValid = v; wrGlobal = g;
    wrSize = sz; wrPriv = p; wrWritable = w; wrNfo = n; wrSideEff = s; wrPpn = ppn;
    @(negedge clk);
    wrEn = 0;
    mValid[idx] = v; mGlob[idx] = g; mSize[idx] = sz; mPriv[idx] = p; mWr[idx] = w;
    mNfo[idx] = n; mSe[idx] = s; mPpn[idx] = ppn; mVpn[idx] = vpn; mCtx[idx] = ctx; mUsed[idx] = 0;
  endtask

  task automatic look(input logic [63:0] va, input logic [1:0] kind, input logic user,
                      input logic [1:0] sel, input logic pm, input logic en, input logic clr);
    logic [12:0] ctx;
    logic [1:0] kc;
    int hi;
    logic eHit, eRead, eWok, eF, eP, eM, fP, fS, fN;
    logic [40:0] ePa;
    logic [50:0] m;
    ctx = (sel == 0) ? primaryCtx : (sel == 1) ? secondaryCtx : 13'd0;
    kc = (sel >= 2) ? 2'd2 : sel;
    hi = -1;
    for (int i = 0; i < 64; i++)
      if (hi < 0 && mValid[i] && (mGlob[i] || mCtx[i] == ctx) &&
          (((va[63:13] ^ mVpn[i]) & bMask(mSize[i])) == 51'd0)) hi = i;
    eHit = 0; eRead = 0; eWok = 0; eF = 0; eP = 0; eM = 0; ePa = '0;
    if (!en) begin
      eRead = 1; eWok = 1; ePa = va[40:0];
      if (clr) sFsr = 0;
    end else if (hi < 0) begin
      eM = 1; sTag = {va[63:13], ctx};
      if (clr) sFsr = 0;
    end else begin
      eHit = 1;
      m = bMask(mSize[hi]);
      ePa = {(mPpn[hi] & m[27:0]) | (va[40:13] & ~m[27:0]), 13'd0};
      fP = mPriv[hi] && user;
      fS = (kind == 2) && mSe[hi];
      fN = (kind != 2) && mNfo[hi];
      eF = fP || fS || fN;
      eP = !eF && (kind == 1) && !mWr[hi];
      if (eF || eP) begin
        sFsr = {fN, fS, fP, kind == 2'd2, kind == 2'd1, kc, pm, sFsr[0] && !clr, 1'b1};
        sFar = va; sTag = {va[63:13], ctx};
      end else begin
        eRead = 1; eWok = mWr[hi]; mUsed[hi] = 1;
        if (clr) sFsr = 0;
      end
    end
    @(negedge clk);
    reqValid = 1; reqVa = va; reqKind = kind; reqUser = user; reqCtxSel = sel;
    privMode = pm; mmuEnable = en; statusClr = clr;
    @(negedge clk);
    reqValid = 0; statusClr = 0;
    chk("R12", "rspValid", 64'(rspValid), 64'd1);
    chk(en ? "R2" : "R11", "rspHit", 64'(rspHit), 64'(eHit));
    chk(en ? "R3" : "R11", "rspPa", 64'(rspPa), 64'(ePa));
    chk(en ? "R5" : "R11", "trapFault", 64'(trapFault), 64'(eF));
    chk(en ? "R6" : "R11", "trapProt", 64'(trapProt), 64'(eP));
    chk(en ? "R10" : "R11", "trapMiss", 64'(trapMiss), 64'(eM));
    chk(en ? "R7" : "R11", "rspRead", 64'(rspRead), 64'(eRead));
    chk(en ? "R7" : "R11", "rspWriteOk", 64'(rspWriteOk), 64'(eWok));
    chk("R8", "faultStatus", 64'(faultStatus), 64'(sFsr));
    chk("R8", "faultAddr", faultAddr, sFar);
    chk("R9", "tagAccess", tagAccess, sTag);
  endtask

  task automatic usedIs(input int idx, input logic exp);
    rdIdx = 6'(idx);
    #1;
    chk("R7", "rdUsed", 64'(rdUsed), 64'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [50:0] vb;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) begin
      mValid[i] = 0; mGlob[i] = 0; mPriv[i] = 0; mWr[i] = 0; mNfo[i] = 0; mSe[i] = 0;
      mUsed[i] = 0; mSize[i] = 0; mVpn[i] = 0; mCtx[i] = 0; mPpn[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "rspValid", 64'(rspValid), 0);
    chk("R13", "traps", 64'({trapFault, trapProt, trapMiss}), 0);
    chk("R13", "faultStatus", 64'(faultStatus), 0);
    chk("R13", "tagAccess", tagAccess, 0);
    rstN = 1;
    @(negedge clk);
    primaryCtx = 13'd5; secondaryCtx = 13'd5;
    look(64'h0000_1234_5678_0000, 2'd0, 0, 2'd0, 0, 1, 0);  // R13 empty array misses

    // R1: one entry per page size, probe last byte in page and first byte past it
    for (int k = 0; k < 4; k++) begin
      vb = 51'(k + 1) << 40;
      putEntry(k, vb, 13'd5, 1, 0, 2'(k), 0, 1, 0, 0, 28'h0ab_cdef);
      look({vb, 13'd0} | ((64'd1 << (13 + 3 * k)) - 1), 2'd0, 0, 2'd0, 0, 1, 0);
      look({vb, 13'd0} + (64'd1 << (13 + 3 * k)), 2'd0, 0, 2'd0, 0, 1, 0);
    end
    // R7 used flag after clean hits
    usedIs(0, 1); usedIs(3, 1); usedIs(4, 0);
    // R2: invalid entry, context mismatch, global entry
    putEntry(4, 51'h7 << 40, 13'd5, 0, 0, 2'd0, 0, 1, 0, 0, 28'h1);
    look({51'h7 << 40, 13'h10}, 2'd0, 0, 2'd0, 0, 1, 0);
    primaryCtx = 13'd9;
    look({51'h1 << 40, 13'h10}, 2'd0, 0, 2'd0, 0, 1, 0);
    putEntry(5, 51'h8 << 40, 13'd3, 1, 1, 2'd1, 0, 1, 0, 0, 28'h2);
    look({51'h8 << 40, 13'h10}, 2'd0, 0, 2'd0, 0, 1, 0);
    // R4: secondary and nucleus contexts
    secondaryCtx = 13'd5;
    look({51'h1 << 40, 13'h20}, 2'd0, 0, 2'd1, 0, 1, 0);
    putEntry(6, 51'h9 << 40, 13'd0, 1, 0, 2'd0, 0, 0, 0, 0, 28'h3);
    look({51'h9 << 40, 13'h0}, 2'd1, 0, 2'd2, 1, 1, 0);   // R4 nucleus + R6 store to read-only
    look({51'h9 << 40, 13'h0}, 2'd0, 0, 2'd3, 0, 1, 0);
    look({51'h9 << 40, 13'h0}, 2'd0, 0, 2'd0, 0, 1, 0);
    // R5: several fault-type bits at once; R8 overwrite
    putEntry(7, 51'hA << 40, 13'd9, 1, 0, 2'd2, 1, 1, 1, 1, 28'h4);
    look({51'hA << 40, 13'h0}, 2'd0, 1, 2'd0, 1, 1, 0);
    look({51'hA << 40, 13'h0}, 2'd2, 1, 2'd0, 0, 1, 0);
    // R8: clear together with fault gives no overwrite; clear alone zeroes
    look({51'hA << 40, 13'h0}, 2'd1, 1, 2'd0, 1, 1, 1);
    look({51'h3F << 40, 13'h0}, 2'd0, 0, 2'd0, 0, 1, 1);
    // R12: lowest index wins
    putEntry(10, 51'hB << 40, 13'd9, 1, 0, 2'd0, 0, 1, 0, 0, 28'h10);
    putEntry(11, 51'hB << 40, 13'd9, 1, 0, 2'd0, 0, 0, 0, 0, 28'h11);
    look({51'hB << 40, 13'h0}, 2'd1, 0, 2'd0, 0, 1, 0);
    usedIs(10, 1); usedIs(11, 0);
    putEntry(63, 51'hC << 40, 13'd9, 1, 0, 2'd3, 0, 1, 0, 0, 28'h20);
    putEntry(62, 51'hC << 40, 13'd0, 1, 1, 2'd0, 0, 0, 0, 0, 28'h21);
    look({51'hC << 40, 13'h0}, 2'd1, 0, 2'd0, 0, 1, 0);
    // R11: translation disabled
    look(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1, 2'd0, 0, 0, 0);
    look({51'hA << 40, 13'h5}, 2'd0, 1, 2'd0, 0, 0, 0);
    // R12: valid drops after one cycle
    @(negedge clk);
    chk("R12", "rspValid idle", 64'(rspValid), 0);

    // random phase
    for (int i = 0; i < 64; i++)
      putEntry(i, {2'($urandom), 37'd0, 12'($urandom)}, 13'($urandom_range(0, 2)),
               ($urandom % 8) != 0, ($urandom % 6) == 0, 2'($urandom),
               ($urandom % 4) == 0, ($urandom % 3) != 0, ($urandom % 6) == 0,
               ($urandom % 5) == 0, 28'($urandom));
    for (int n = 0; n < 600; n++) begin
      int idx;
      logic [63:0] va;
      idx = $urandom_range(0, 63);
      primaryCtx = 13'($urandom_range(0, 2));
      secondaryCtx = 13'($urandom_range(0, 2));
      va = {mVpn[idx], 13'd0} ^ 64'($urandom_range(0, 32'h3FF_FFFF));
      look(va, 2'($urandom_range(0, 2)), 1'($urandom), 2'($urandom),
           1'($urandom), ($urandom % 10) != 0, ($urandom % 7) == 0);
      if (n % 50 == 49)
        putEntry($urandom_range(0, 63), {2'($urandom), 37'd0, 12'($urandom)},
                 13'($urandom_range(0, 2)), 1, 0, 2'($urandom), 0, 1, 0, 0, 28'($urandom));
    end
    for (int i = 0; i < 64; i++) usedIs(i, mUsed[i]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule